// File: doc/BRIEF.md
# Serial Configuration Loader with Latch Routing

This block takes configuration words from a three-wire serial port (data, serial clock, load strobe) into a 23-bit shift register. All three serial wires are brought into the system clock domain through flop chains, and edges are found there. Each rising serial clock edge, while the load strobe is low, shifts one bit in. The most significant bit comes first, so the two routing bits arrive last and sit at positions 1 and 0.

A rising load strobe copies the word into one of four latches: the reference and divider latches of an auxiliary channel and of a main channel. The routing bits pick the latch, and each latch type has its own field layout. The latched fields drive the synthesizer datapath: reference divide value, swallow count, main count, prescaler select, phase polarity, pump current select and test-select bits. A monitor output shows either the lock-detect input or one of four divider clocks. The latched select and test bits choose which.

Top module: `ser_cfg_loader`

## Requirements
- R1: After reset, every latched field output is zero and `mon_o` equals `lock_i`.
- R2: Each rising edge of `ser_clk_i`, taken while the load strobe is low, shifts `ser_dat_i` into position 0 and moves every bit up one position. After 23 bits, the first bit sent sits at position 22.
- R3: On a rising `ser_load_i`, the bits at positions 1 and 0, written as {pos1,pos0}, pick the target latch: 00 auxiliary reference, 01 main reference, 10 auxiliary divider, 11 main divider. A reference word leaves both divider latches unchanged.
- R4: Reference word layout: pos2 is test-select bit 0 and pos3 is test-select bit 1. Positions 4 to 17 hold the 14-bit reference value, least significant bit at 4. Pos18 is the pump current select. Positions 19 to 22 are ignored.
- R5: Divider word layout: pos2 is the monitor select, pos3 the prescaler select and pos4 the phase polarity. Positions 5 to 11 hold the 7-bit swallow count (lsb at 5). Positions 12 to 22 hold the 11-bit main count (lsb at 12).
- R6: Latches change only on a rising load strobe, and the latches not selected keep their contents. Every latched output is updated within 8 system clocks of the strobe rising.
- R7: Serial clock edges that arrive while `ser_load_i` is high do not alter the shift register.
- R8: When both monitor select bits are 0, `mon_o` equals `lock_i`. Otherwise `mon_o` follows a source chosen by the OR of the two test-select fields: 00 `aux_ref_clk_i`, 01 `main_ref_clk_i`, 10 `aux_cmp_clk_i`, 11 `main_cmp_clk_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial shift clock (asynchronous) |
| ser_dat_i | input | 1 | Serial data |
| ser_load_i | input | 1 | Load strobe, transfer on rising edge |
| lock_i | input | 1 | Lock-detect signal for the monitor |
| aux_ref_clk_i | input | 1 | Auxiliary reference divider output |
| main_ref_clk_i | input | 1 | Main reference divider output |
| aux_cmp_clk_i | input | 1 | Auxiliary feedback divider output |
| main_cmp_clk_i | input | 1 | Main feedback divider output |
| aux_rdiv_o | output | 14 | Auxiliary reference divide value |
| aux_tsel_o | output | 2 | Auxiliary test-select bits |
| aux_ipump_o | output | 1 | Auxiliary pump current select |
| main_rdiv_o | output | 14 | Main reference divide value |
| main_tsel_o | output | 2 | Main test-select bits |
| main_ipump_o | output | 1 | Main pump current select |
| aux_ndiv_o | output | 11 | Auxiliary main count |
| aux_swal_o | output | 7 | Auxiliary swallow count |
| aux_psc_o | output | 1 | Auxiliary prescaler select |
| aux_pol_o | output | 1 | Auxiliary phase polarity |
| aux_msel_o | output | 1 | Auxiliary monitor select |
| main_ndiv_o | output | 11 | Main main count |
| main_swal_o | output | 7 | Main swallow count |
| main_psc_o | output | 1 | Main prescaler select |
| main_pol_o | output | 1 | Main phase polarity |
| main_msel_o | output | 1 | Main monitor select |
| mon_o | output | 1 | Monitor output |

## Verification
The bench sends words whose fields sit at their limits: reference value 3 and 16383, counts of all ones, nonzero ignored bits. After every load it compares all four latches against a model. A design that swaps the routing bits, or that has the field offsets one position off, would write the wrong latch or corrupt a neighbouring field. A latch with a loose write enable would show changes in latches that were not addressed. A word clocked in while the strobe is held high must leave the shift register as it was; a design that shifts anyway would reload altered data. The monitor is driven through each test-select code and through the OR of the two channels. A wrong mux index or a missing lock-detect fallback shows at `mon_o`.

// File: rtl/ser_cfg_pkg.sv
package ser_cfg_pkg;
  localparam int WORD_W   = 23;
  localparam int R_W      = 14;
  localparam int N_W      = 11;
  localparam int A_W      = 7;
  localparam int TSEL_W   = 2;
  localparam int NCH      = 2;
  localparam int ROUTE_LO = 0;
  localparam int ROUTE_HI = 1;
  // reference word layout
  localparam int REF_T_LSB  = 2;
  localparam int REF_R_LSB  = REF_T_LSB + TSEL_W;
  localparam int REF_CP_POS = REF_R_LSB + R_W;
  // divider word layout
  localparam int DIV_MS_POS  = 2;
  localparam int DIV_PS_POS  = 3;
  localparam int DIV_POL_POS = 4;
  localparam int DIV_A_LSB   = 5;
  localparam int DIV_N_LSB   = DIV_A_LSB + A_W;

  typedef enum logic [1:0] {
    DST_AUX_REF  = 2'b00,
    DST_MAIN_REF = 2'b01,
    DST_AUX_DIV  = 2'b10,
    DST_MAIN_DIV = 2'b11
  } dst_e;

  typedef struct packed {
    logic [TSEL_W-1:0] tsel;
    logic [R_W-1:0]    rdiv;
    logic              ipump;
  } ref_cfg_t;

  typedef struct packed {
    logic           msel;
    logic           psc;
    logic           pol;
    logic [A_W-1:0] swal;
    logic [N_W-1:0] ndiv;
  } div_cfg_t;

  function automatic ref_cfg_t decode_ref(logic [WORD_W-1:0] w);
    ref_cfg_t r;
    r.tsel  = w[REF_T_LSB +: TSEL_W];
    r.rdiv  = w[REF_R_LSB +: R_W];
    r.ipump = w[REF_CP_POS];
    return r;
  endfunction

  function automatic div_cfg_t decode_div(logic [WORD_W-1:0] w);
    div_cfg_t d;
    d.msel = w[DIV_MS_POS];
    d.psc  = w[DIV_PS_POS];
    d.pol  = w[DIV_POL_POS];
    d.swal = w[DIV_A_LSB +: A_W];
    d.ndiv = w[DIV_N_LSB +: N_W];
    return d;
  endfunction
endpackage

// File: rtl/ser_cfg_sync.sv
module ser_cfg_sync #(
  parameter int STAGES = 2,
  parameter int W      = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] pipe [STAGES];
  logic [W-1:0] prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) pipe[s] <= '0;
      prev <= '0;
    end else begin
      pipe[0] <= d_i;
      for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
      prev <= pipe[STAGES-1];
    end
  end

  assign q_o    = pipe[STAGES-1];
  assign rise_o = q_o & ~prev;

  AST_RISE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_o != '0) |=> ((rise_o & $past(rise_o)) == '0)); // R2
endmodule

// File: rtl/ser_cfg_shift.sv
module ser_cfg_shift #(
  parameter int W = 23
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         bit_i,
  output logic [W-1:0] word_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   word_o <= '0;
    else if (en_i) word_o <= {word_o[W-2:0], bit_i};
  end

  AST_SHIFT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> (word_o == {$past(word_o[W-2:0]), $past(bit_i)})); // R2
  AST_SHIFT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(word_o)); // R7
endmodule

// File: rtl/ser_cfg_bank.sv
module ser_cfg_bank
  import ser_cfg_pkg::*;
(
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      load_i,
  input  logic [WORD_W-1:0]         word_i,
  output ref_cfg_t [NCH-1:0]        ref_o,
  output div_cfg_t [NCH-1:0]        div_o
);
  dst_e     dst;
  ref_cfg_t ref_dec;
  div_cfg_t div_dec;

  assign dst     = dst_e'({word_i[ROUTE_HI], word_i[ROUTE_LO]});
  assign ref_dec = decode_ref(word_i);
  assign div_dec = decode_div(word_i);

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    localparam dst_e REF_ID = (ch == 0) ? DST_AUX_REF : DST_MAIN_REF;
    localparam dst_e DIV_ID = (ch == 0) ? DST_AUX_DIV : DST_MAIN_DIV;
    logic ref_we, div_we;
    assign ref_we = load_i && (dst == REF_ID);
    assign div_we = load_i && (dst == DIV_ID);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ref_o[ch] <= '0;
        div_o[ch] <= '0;
      end else begin
        if (ref_we) ref_o[ch] <= ref_dec;
        if (div_we) div_o[ch] <= div_dec;
      end
    end
  end

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ($stable(ref_o) && $stable(div_o))); // R6
  AST_REF_SPARES_DIV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !word_i[ROUTE_HI]) |=> $stable(div_o)); // R3
endmodule

// File: rtl/ser_cfg_mon.sv
module ser_cfg_mon #(
  parameter int TSEL_W = 2,
  localparam int NSRC  = 1 << TSEL_W
) (
  input  logic              sel_i,
  input  logic [TSEL_W-1:0] tsel_i,
  input  logic              lock_i,
  input  logic [NSRC-1:0]   src_i,
  output logic              mon_o
);
  assign mon_o = sel_i ? src_i[tsel_i] : lock_i;
endmodule

// File: rtl/ser_cfg_loader.sv
module ser_cfg_loader
  import ser_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ser_clk_i,
  input  logic              ser_dat_i,
  input  logic              ser_load_i,
  input  logic              lock_i,
  input  logic              aux_ref_clk_i,
  input  logic              main_ref_clk_i,
  input  logic              aux_cmp_clk_i,
  input  logic              main_cmp_clk_i,
  output logic [R_W-1:0]    aux_rdiv_o,
  output logic [TSEL_W-1:0] aux_tsel_o,
  output logic              aux_ipump_o,
  output logic [R_W-1:0]    main_rdiv_o,
  output logic [TSEL_W-1:0] main_tsel_o,
  output logic              main_ipump_o,
  output logic [N_W-1:0]    aux_ndiv_o,
  output logic [A_W-1:0]    aux_swal_o,
  output logic              aux_psc_o,
  output logic              aux_pol_o,
  output logic              aux_msel_o,
  output logic [N_W-1:0]    main_ndiv_o,
  output logic [A_W-1:0]    main_swal_o,
  output logic              main_psc_o,
  output logic              main_pol_o,
  output logic              main_msel_o,
  output logic              mon_o
);
  localparam int BIT_CLK = 0;
  localparam int BIT_DAT = 1;
  localparam int BIT_LD  = 2;

  logic [2:0]        sync_q, sync_rise;
  logic              shift_en, load_stb, msel_any;
  logic [WORD_W-1:0] word;
  ref_cfg_t [NCH-1:0] ref_q;
  div_cfg_t [NCH-1:0] div_q;

  ser_cfg_sync #(.STAGES(SYNC_STAGES), .W(3)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ser_load_i, ser_dat_i, ser_clk_i}),
    .q_o   (sync_q),
    .rise_o(sync_rise)
  );

  // shifting is blocked while the load strobe is high
  assign shift_en = sync_rise[BIT_CLK] & ~sync_q[BIT_LD];
  assign load_stb = sync_rise[BIT_LD];

  ser_cfg_shift #(.W(WORD_W)) u_shift (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (shift_en),
    .bit_i (sync_q[BIT_DAT]),
    .word_o(word)
  );

  ser_cfg_bank u_bank (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load_stb),
    .word_i(word),
    .ref_o (ref_q),
    .div_o (div_q)
  );

  assign msel_any = div_q[0].msel | div_q[1].msel;

  ser_cfg_mon #(.TSEL_W(TSEL_W)) u_mon (
    .sel_i (msel_any),
    .tsel_i(ref_q[0].tsel | ref_q[1].tsel),
    .lock_i(lock_i),
    .src_i ({main_cmp_clk_i, aux_cmp_clk_i, main_ref_clk_i, aux_ref_clk_i}),
    .mon_o (mon_o)
  );

  assign aux_rdiv_o   = ref_q[0].rdiv;
  assign aux_tsel_o   = ref_q[0].tsel;
  assign aux_ipump_o  = ref_q[0].ipump;
  assign main_rdiv_o  = ref_q[1].rdiv;
  assign main_tsel_o  = ref_q[1].tsel;
  assign main_ipump_o = ref_q[1].ipump;
  assign aux_ndiv_o   = div_q[0].ndiv;
  assign aux_swal_o   = div_q[0].swal;
  assign aux_psc_o    = div_q[0].psc;
  assign aux_pol_o    = div_q[0].pol;
  assign aux_msel_o   = div_q[0].msel;
  assign main_ndiv_o  = div_q[1].ndiv;
  assign main_swal_o  = div_q[1].swal;
  assign main_psc_o   = div_q[1].psc;
  assign main_pol_o   = div_q[1].pol;
  assign main_msel_o  = div_q[1].msel;

  AST_LOAD_BLOCKS_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_q[BIT_LD] |-> !shift_en); // R7
  AST_MON_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!aux_msel_o && !main_msel_o) |-> (mon_o == lock_i)); // R8
endmodule

// File: tb/ser_cfg_loader_test.sv
module ser_cfg_loader_test;
  typedef struct packed {
    logic [1:0]  dst;  // {pos1,pos0}
    logic [13:0] r;
    logic [1:0]  t;
    logic        cp;
    logic [10:0] n;
    logic [6:0]  a;
    logic        ms;
    logic        ps;
    logic        pol;
    logic [3:0]  pad;
  } vec_t;

  localparam int NV = 8;
  localparam logic [43:0] VECS [NV] = '{
    {2'b00, 14'd3,     2'b01, 1'b1, 11'd0,    7'd0,   1'b0, 1'b0, 1'b0, 4'hF},
    {2'b01, 14'd16383, 2'b10, 1'b0, 11'd0,    7'd0,   1'b0, 1'b0, 1'b0, 4'hA},
    {2'b10, 14'd0,     2'b00, 1'b0, 11'd2047, 7'd127, 1'b0, 1'b1, 1'b1, 4'h0},
    {2'b11, 14'd0,     2'b00, 1'b0, 11'd3,    7'd0,   1'b1, 1'b0, 1'b1, 4'h0},
    {2'b00, 14'd10922, 2'b11, 1'b0, 11'd0,    7'd0,   1'b0, 1'b0, 1'b0, 4'h5},
    {2'b11, 14'd0,     2'b00, 1'b0, 11'd1365, 7'd85,  1'b0, 1'b1, 1'b0, 4'h0},
    {2'b01, 14'd5461,  2'b00, 1'b1, 11'd0,    7'd0,   1'b0, 1'b0, 1'b0, 4'h0},
    {2'b10, 14'd0,     2'b00, 1'b0, 11'd682,  7'd42,  1'b0, 1'b0, 1'b0, 4'h0}
  };

  logic clk = 0, rst_n = 0;
  logic s_clk = 0, s_dat = 0, s_ld = 0, lock = 0;
  logic [3:0] src = '0; // {main_cmp, aux_cmp, main_ref, aux_ref}
  logic [13:0] aux_rdiv, main_rdiv;
  logic [1:0]  aux_tsel, main_tsel;
  logic        aux_ipump, main_ipump;
  logic [10:0] aux_ndiv, main_ndiv;
  logic [6:0]  aux_swal, main_swal;
  logic        aux_psc, aux_pol, aux_msel, main_psc, main_pol, main_msel, mon;

  int checks = 0, errors = 0;
  vec_t exp_ref [2];
  vec_t exp_div [2];

  always #5 clk = ~clk;

  ser_cfg_loader uut (
    .clk_i(clk), .rst_ni(rst_n), .ser_clk_i(s_clk), .ser_dat_i(s_dat), .ser_load_i(s_ld),
    .lock_i(lock), .aux_ref_clk_i(src[0]), .main_ref_clk_i(src[1]),
    .aux_cmp_clk_i(src[2]), .main_cmp_clk_i(src[3]),
    .aux_rdiv_o(aux_rdiv), .aux_tsel_o(aux_tsel), .aux_ipump_o(aux_ipump),
    .main_rdiv_o(main_rdiv), .main_tsel_o(main_tsel), .main_ipump_o(main_ipump),
    .aux_ndiv_o(aux_ndiv), .aux_swal_o(aux_swal), .aux_psc_o(aux_psc),
    .aux_pol_o(aux_pol), .aux_msel_o(aux_msel),
    .main_ndiv_o(main_ndiv), .main_swal_o(main_swal), .main_psc_o(main_psc),
    .main_pol_o(main_pol), .main_msel_o(main_msel), .mon_o(mon)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [22:0] mk_word(vec_t v);
    logic [22:0] w = '0;
    w[1:0] = v.dst;
    if (!v.dst[1]) begin
      w[3:2] = v.t; w[17:4] = v.r; w[18] = v.cp; w[22:19] = v.pad;
    end else begin
      w[2] = v.ms; w[3] = v.ps; w[4] = v.pol; w[11:5] = v.a; w[22:12] = v.n;
    end
    return w;
  endfunction

  function automatic vec_t mkv(logic [1:0] dst, logic [13:0] r, logic [1:0] t, logic cp,
                               logic [10:0] n, logic [6:0] a, logic ms, logic ps, logic pol);
    vec_t v;
    v.dst = dst; v.r = r; v.t = t; v.cp = cp; v.n = n; v.a = a;
    v.ms = ms; v.ps = ps; v.pol = pol; v.pad = 4'h9;
    return v;
  endfunction

  task automatic shift_word(input logic [22:0] w);
    for (int i = 22; i >= 0; i--) begin
      @(negedge clk); s_dat = w[i];
      repeat (3) @(negedge clk); s_clk = 1;
      repeat (4) @(negedge clk); s_clk = 0;
    end
  endtask

  task automatic pulse_load();
    repeat (2) @(negedge clk); s_ld = 1;
    repeat (4) @(negedge clk); s_ld = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic apply(input vec_t v);
    if (!v.dst[1]) exp_ref[v.dst[0]] = v; else exp_div[v.dst[0]] = v;
  endtask

  task automatic send(input vec_t v);
    shift_word(mk_word(v));
    pulse_load();
    apply(v);
  endtask

  task automatic check_all(input string tag);
    chk(aux_rdiv == exp_ref[0].r,   {tag, " R4 aux rdiv"}, 32'(aux_rdiv), 32'(exp_ref[0].r));
    chk(aux_tsel == exp_ref[0].t,   {tag, " R4 aux tsel"}, 32'(aux_tsel), 32'(exp_ref[0].t));
    chk(aux_ipump == exp_ref[0].cp, {tag, " R4 aux ipump"}, 32'(aux_ipump), 32'(exp_ref[0].cp));
    chk(main_rdiv == exp_ref[1].r,  {tag, " R3 main rdiv"}, 32'(main_rdiv), 32'(exp_ref[1].r));
    chk(main_tsel == exp_ref[1].t,  {tag, " R3 main tsel"}, 32'(main_tsel), 32'(exp_ref[1].t));
    chk(main_ipump == exp_ref[1].cp, {tag, " R3 main ipump"}, 32'(main_ipump), 32'(exp_ref[1].cp));
    chk(aux_ndiv == exp_div[0].n,   {tag, " R5 aux ndiv"}, 32'(aux_ndiv), 32'(exp_div[0].n));
    chk(aux_swal == exp_div[0].a,   {tag, " R5 aux swal"}, 32'(aux_swal), 32'(exp_div[0].a));
    chk({aux_msel, aux_psc, aux_pol} == {exp_div[0].ms, exp_div[0].ps, exp_div[0].pol},
        {tag, " R5 aux flags"}, 32'({aux_msel, aux_psc, aux_pol}),
        32'({exp_div[0].ms, exp_div[0].ps, exp_div[0].pol}));
    chk(main_ndiv == exp_div[1].n,  {tag, " R6 main ndiv"}, 32'(main_ndiv), 32'(exp_div[1].n));
    chk(main_swal == exp_div[1].a,  {tag, " R6 main swal"}, 32'(main_swal), 32'(exp_div[1].a));
    chk({main_msel, main_psc, main_pol} == {exp_div[1].ms, exp_div[1].ps, exp_div[1].pol},
        {tag, " R6 main flags"}, 32'({main_msel, main_psc, main_pol}),
        32'({exp_div[1].ms, exp_div[1].ps, exp_div[1].pol}));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < 2; c++) begin exp_ref[c] = '0; exp_div[c] = '0; end
    lock = 1;
    repeat (3) @(negedge clk); rst_n = 1;
    repeat (2) @(negedge clk);
    // R1 reset state
    check_all("R1 reset");
    chk(mon == 1'b1, "R1 mon after reset", 32'(mon), 32'd1);

    // R2..R6 table walk; every latch checked after each load
    for (int i = 0; i < NV; i++) begin
      send(vec_t'(VECS[i]));
      check_all($sformatf("R2 vec%0d", i));
    end

    // R7: clock edges under a high strobe must not shift
    send(mkv(2'b10, 14'd0, 2'b00, 1'b0, 11'd1000, 7'd99, 1'b0, 1'b1, 1'b0));
    @(negedge clk); s_ld = 1;
    shift_word(mk_word(mkv(2'b10, 14'd0, 2'b00, 1'b0, 11'd5, 7'd1, 1'b0, 1'b0, 1'b1)));
    @(negedge clk); s_ld = 0;
    pulse_load();
    chk(aux_ndiv == 11'd1000, "R7 aux ndiv after blocked shift", 32'(aux_ndiv), 32'd1000);
    chk(aux_swal == 7'd99, "R7 aux swal after blocked shift", 32'(aux_swal), 32'd99);
    check_all("R7");

    // R8 lock path with both select bits low
    send(mkv(2'b10, 14'd0, 2'b00, 1'b0, 11'd7, 7'd1, 1'b0, 1'b0, 1'b0));
    send(mkv(2'b11, 14'd0, 2'b00, 1'b0, 11'd8, 7'd2, 1'b0, 1'b0, 1'b0));
    send(mkv(2'b01, 14'd100, 2'b00, 1'b0, 11'd0, 7'd0, 1'b0, 1'b0, 1'b0));
    src = 4'hF;
    lock = 0; @(negedge clk);
    chk(mon == 1'b0, "R8 mon follows lock low", 32'(mon), 32'd0);
    lock = 1; @(negedge clk);
    chk(mon == 1'b1, "R8 mon follows lock high", 32'(mon), 32'd1);

    // R8 source selection per test-select code
    send(mkv(2'b10, 14'd0, 2'b00, 1'b0, 11'd7, 7'd1, 1'b1, 1'b0, 1'b0));
    for (int s = 0; s < 4; s++) begin
      send(mkv(2'b00, 14'd50, 2'(s), 1'b0, 11'd0, 7'd0, 1'b0, 1'b0, 1'b0));
      lock = 0;
      src = 4'b0001 << s; @(negedge clk);
      chk(mon == 1'b1, $sformatf("R8 sel %0d picks source", s), 32'(mon), 32'd1);
      src = ~(4'b0001 << s); @(negedge clk);
      chk(mon == 1'b0, $sformatf("R8 sel %0d rejects others", s), 32'(mon), 32'd0);
    end

    // R8: OR of both test fields, select from the main divider only
    send(mkv(2'b10, 14'd0, 2'b00, 1'b0, 11'd7, 7'd1, 1'b0, 1'b0, 1'b0));
    send(mkv(2'b11, 14'd0, 2'b00, 1'b0, 11'd9, 7'd3, 1'b1, 1'b0, 1'b0));
    send(mkv(2'b00, 14'd60, 2'b01, 1'b0, 11'd0, 7'd0, 1'b0, 1'b0, 1'b0));
    send(mkv(2'b01, 14'd70, 2'b10, 1'b0, 11'd0, 7'd0, 1'b0, 1'b0, 1'b0));
    src = 4'b1000; @(negedge clk);
    chk(mon == 1'b1, "R8 OR of test fields selects main cmp", 32'(mon), 32'd1);
    src = 4'b0111; @(negedge clk);
    chk(mon == 1'b0, "R8 OR of test fields rejects others", 32'(mon), 32'd0);
    check_all("R8");

    // R1 reset in mid-run clears all latches
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk); rst_n = 1;
    for (int c = 0; c < 2; c++) begin exp_ref[c] = '0; exp_div[c] = '0; end
    lock = 1; @(negedge clk);
    check_all("R1 mid reset");
    chk(mon == 1'b1, "R1 mon after mid reset", 32'(mon), 32'd1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule